// File: doc/BRIEF.md
# Scrambled Single-Port RAM Wrapper

This block sits around a single-port synchronous RAM and stores every word in scrambled form. A request carries a word address, write data, per-byte write enables and a write flag. A read returns its data one cycle after the request, together with a one-cycle valid pulse. The block keeps a 128-bit cipher key, a data nonce and an address nonce. All three are zero after reset and are replaced as a set through a load strobe. Scrambling is never bypassed.

For each request the block forms a 64-bit counter value from the data nonce and the logical word address. It presents that value and the key on an outgoing port, and an external cipher core returns a keystream block in the same cycle. On a write, each byte first goes through a fixed substitution-permutation bijection and is then XORed with the keystream. A read strips the keystream first and then inverts the byte bijection. The RAM row used is not the logical address. It is the logical address passed through the same kind of network, keyed with the address nonce. Loading a new key set leaves the stored words unreadable as plaintext. Nothing is re-encrypted.

Top module: `scram_ram`

## Requirements
- R1: After reset, `ks_key_o` is all zero and the nonce part of `ks_iv_o` (bits 63 down to the address width) is zero.
- R2: When `key_load_i` is high at a clock edge, key and both nonces take the values on `key_i`, `dnonce_i` and `anonce_i`. A request in that same cycle still uses the previous set. Requests in later cycles use the new set.
- R3: `ks_iv_o` equals `{data nonce, addr_i}`, with the logical address in the low bits, and `ks_key_o` equals the stored key.
- R4: A read returns the plaintext last written at that logical address under the same key set. A write stores, in each byte lane, F(byte) XOR the keystream byte. F is the substitution-permutation network of width 8 with key zero and BYTE_ROUNDS rounds. When DATA_W is at most 64, the keystream is `ks_i[DATA_W-1:0]`.
- R5: The network of width W and key K runs each round as follows. First XOR with K. Then map every complete nibble from bit 0 upward through the 4-bit table 0..F -> C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. Then reverse the bit order. Then move the even-indexed bits to the low half and the odd-indexed bits to the high half, in order; an odd top bit stays in place. After the last round the state is XORed with K once more.
- R6: Only bytes whose enable bit is set are changed by a write. The other bytes of that word keep their stored value.
- R7: The RAM row is the network of width AW with key equal to the address nonce and ADDR_ROUNDS rounds, applied to the logical address. Every logical address therefore maps to its own row.
- R8: A read request produces `rvalid_o` high for exactly the next cycle, with `rdata_o` valid in that cycle. Writes and idle cycles produce no valid pulse.
- R9: After a new key set is loaded without rewriting, a read returns the inverse byte network applied to (stored word XOR new keystream). The stored word is taken from the row selected by the new address nonce. The old data is not re-encrypted.
- R10: With DATA_W above 64 and REPLICATE set, bit i of the word uses keystream bit `ks_i[i mod 64]`. A round count of zero makes the corresponding network a pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_load_i | input | 1 | Replace key and nonces at this edge |
| key_i | input | 128 | New cipher key |
| dnonce_i | input | 64-AW | New data nonce |
| anonce_i | input | AW | New address nonce |
| req_i | input | 1 | Request strobe |
| we_i | input | 1 | Request is a write |
| addr_i | input | AW | Logical word address |
| wdata_i | input | DATA_W | Write data |
| be_i | input | DATA_W/8 | Byte write enables |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DATA_W | Read data |
| ks_iv_o | output | 64 | Counter value for the cipher core |
| ks_key_o | output | 128 | Key for the cipher core |
| ks_i | input | KS_LANES*64 | Keystream from the cipher core |

## Verification
A key-set load and a RAM request can share one clock edge. The key register changes at that edge, while the request has already used the outgoing counter value and its row mapping. The bench asserts the load strobe together with a write in one case and together with a read in another. It then checks that the write was scrambled under the old set, and that the read returned the word decoded with the old set. The expected words come from a bench model that tracks the physical rows and the key set in force each cycle.

// File: rtl/scram_ram_pkg.sv
package scram_ram_pkg;

   localparam int IV_W  = 64;
   localparam int KEY_W = 128;

   function automatic logic [3:0] sbox4_fwd(input logic [3:0] x);
      logic [3:0] y;
      case (x)
         4'h0: y = 4'hC;
         4'h1: y = 4'h5;
         4'h2: y = 4'h6;
         4'h3: y = 4'hB;
         4'h4: y = 4'h9;
         4'h5: y = 4'h0;
         4'h6: y = 4'hA;
         4'h7: y = 4'hD;
         4'h8: y = 4'h3;
         4'h9: y = 4'hE;
         4'hA: y = 4'hF;
         4'hB: y = 4'h8;
         4'hC: y = 4'h4;
         4'hD: y = 4'h7;
         4'hE: y = 4'h1;
         default: y = 4'h2;
      endcase
      return y;
   endfunction

   function automatic logic [3:0] sbox4_inv(input logic [3:0] x);
      logic [3:0] y;
      case (x)
         4'h0: y = 4'h5;
         4'h1: y = 4'hE;
         4'h2: y = 4'hF;
         4'h3: y = 4'h8;
         4'h4: y = 4'hC;
         4'h5: y = 4'h1;
         4'h6: y = 4'h2;
         4'h7: y = 4'hD;
         4'h8: y = 4'hB;
         4'h9: y = 4'h4;
         4'hA: y = 4'h6;
         4'hB: y = 4'h3;
         4'hC: y = 4'h0;
         4'hD: y = 4'h7;
         4'hE: y = 4'h9;
         default: y = 4'hA;
      endcase
      return y;
   endfunction

endpackage

// File: rtl/scram_snp.sv
module scram_snp
   import scram_ram_pkg::*;
#(
   parameter int W       = 8,
   parameter int ROUNDS  = 2,
   parameter bit INVERSE = 1'b0
) (
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] key_i,
   output logic [W-1:0] data_o
);

   localparam int NIB  = W / 4;
   localparam int HALF = W / 2;

   if (W < 2) begin : g_bad_w
      $error("scram_snp: W must be at least 2");
   end
   if (ROUNDS < 0) begin : g_bad_r
      $error("scram_snp: ROUNDS must not be negative");
   end

   function automatic logic [W-1:0] sub_layer(input logic [W-1:0] s, input bit inv);
      logic [W-1:0] r;
      r = s;
      for (int n = 0; n < NIB; n++) begin
         r[4*n +: 4] = inv ? sbox4_inv(s[4*n +: 4]) : sbox4_fwd(s[4*n +: 4]);
      end
      return r;
   endfunction

   function automatic logic [W-1:0] flip(input logic [W-1:0] s);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) begin
         r[i] = s[W-1-i];
      end
      return r;
   endfunction

   function automatic logic [W-1:0] perm_fwd(input logic [W-1:0] s);
      logic [W-1:0] r;
      r = s;
      for (int i = 0; i < HALF; i++) begin
         r[i]        = s[2*i];
         r[i + HALF] = s[2*i + 1];
      end
      return r;
   endfunction

   function automatic logic [W-1:0] perm_inv(input logic [W-1:0] s);
      logic [W-1:0] r;
      r = s;
      for (int i = 0; i < HALF; i++) begin
         r[2*i]     = s[i];
         r[2*i + 1] = s[i + HALF];
      end
      return r;
   endfunction

   if (ROUNDS == 0) begin : g_bypass
      logic unused_key;
      assign unused_key = ^key_i;
      assign data_o     = data_i;
   end else if (!INVERSE) begin : g_fwd
      logic [W-1:0] st;
      always_comb begin
         st = data_i;
         for (int r = 0; r < ROUNDS; r++) begin
            st = perm_fwd(flip(sub_layer(st ^ key_i, 1'b0)));
         end
         data_o = st ^ key_i;
      end
   end else begin : g_inv
      logic [W-1:0] st;
      always_comb begin
         st = data_i ^ key_i;
         for (int r = 0; r < ROUNDS; r++) begin
            st = sub_layer(flip(perm_inv(st)), 1'b1) ^ key_i;
         end
         data_o = st;
      end
   end

endmodule

// File: rtl/scram_keystore.sv
module scram_keystore
   import scram_ram_pkg::*;
#(
   parameter int DN_W = 55,
   parameter int AN_W = 9
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [KEY_W-1:0] key_i,
   input  logic [DN_W-1:0]  dnonce_i,
   input  logic [AN_W-1:0]  anonce_i,
   output logic [KEY_W-1:0] key_o,
   output logic [DN_W-1:0]  dnonce_o,
   output logic [AN_W-1:0]  anonce_o
);

   logic [KEY_W-1:0] key_q;
   logic [DN_W-1:0]  dn_q;
   logic [AN_W-1:0]  an_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         key_q <= '0;
         dn_q  <= '0;
         an_q  <= '0;
      end else if (load_i) begin
         key_q <= key_i;
         dn_q  <= dnonce_i;
         an_q  <= anonce_i;
      end
   end

   assign key_o    = key_q;
   assign dnonce_o = dn_q;
   assign anonce_o = an_q;

   assert_key_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (key_o == $past(key_i)) && (dnonce_o == $past(dnonce_i))
                 && (anonce_o == $past(anonce_i)));

   assert_key_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(key_o) && $stable(dnonce_o) && $stable(anonce_o));

endmodule

// File: rtl/scram_spram.sv
module scram_spram #(
   parameter int DEPTH  = 512,
   parameter int DATA_W = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int NB    = DATA_W / 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              we_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [NB-1:0]     be_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk_i) begin
      if (en_i && we_i) begin
         for (int b = 0; b < NB; b++) begin
            if (be_i[b]) begin
               mem[addr_i][8*b +: 8] <= wdata_i[8*b +: 8];
            end
         end
      end
      if (en_i && !we_i) begin
         rdata_q <= mem[addr_i];
      end
   end

   assign rdata_o = rdata_q;

   assert_rdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(en_i && !we_i) |=> $stable(rdata_o));

endmodule

// File: rtl/scram_ram.sv
module scram_ram
   import scram_ram_pkg::*;
#(
   parameter int DEPTH       = 512,
   parameter int DATA_W      = 32,
   parameter int BYTE_ROUNDS = 2,
   parameter int ADDR_ROUNDS = 2,
   parameter bit REPLICATE   = 1'b0,
   localparam int AW         = $clog2(DEPTH),
   localparam int NB         = DATA_W / 8,
   localparam int DN_W       = IV_W - AW,
   localparam int KS_LANES   = (DATA_W <= IV_W || REPLICATE) ? 1 : (DATA_W + IV_W - 1) / IV_W
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     key_load_i,
   input  logic [KEY_W-1:0]         key_i,
   input  logic [DN_W-1:0]          dnonce_i,
   input  logic [AW-1:0]            anonce_i,
   input  logic                     req_i,
   input  logic                     we_i,
   input  logic [AW-1:0]            addr_i,
   input  logic [DATA_W-1:0]        wdata_i,
   input  logic [NB-1:0]            be_i,
   output logic                     rvalid_o,
   output logic [DATA_W-1:0]        rdata_o,
   output logic [IV_W-1:0]          ks_iv_o,
   output logic [KEY_W-1:0]         ks_key_o,
   input  logic [KS_LANES*IV_W-1:0] ks_i
);

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("scram_ram: DATA_W must be a positive multiple of 8");
   end
   if (AW < 2 || AW >= IV_W) begin : g_bad_depth
      $error("scram_ram: DEPTH out of range");
   end
   if (ADDR_ROUNDS > 0 && (1 << AW) != DEPTH) begin : g_bad_pow2
      $error("scram_ram: address remapping needs a power-of-two DEPTH");
   end

   // key set
   logic [KEY_W-1:0] key_q;
   logic [DN_W-1:0]  dnonce_q;
   logic [AW-1:0]    anonce_q;

   scram_keystore #(
      .DN_W (DN_W),
      .AN_W (AW)
   ) u_keystore (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (key_load_i),
      .key_i    (key_i),
      .dnonce_i (dnonce_i),
      .anonce_i (anonce_i),
      .key_o    (key_q),
      .dnonce_o (dnonce_q),
      .anonce_o (anonce_q)
   );

   // counter value handed to the cipher core
   assign ks_iv_o  = {dnonce_q, addr_i};
   assign ks_key_o = key_q;

   // keystream fitted to the data width
   logic [DATA_W-1:0] ks_word;
   logic              unused_ks;
   assign unused_ks = ^ks_i;

   if (DATA_W <= IV_W) begin : g_ks_trunc
      assign ks_word = ks_i[DATA_W-1:0];
   end else if (REPLICATE) begin : g_ks_rep
      for (genvar g = 0; g < DATA_W; g++) begin : g_bit
         assign ks_word[g] = ks_i[g % IV_W];
      end
   end else begin : g_ks_lanes
      assign ks_word = ks_i[DATA_W-1:0];
   end

   // physical row
   logic [AW-1:0] phys_addr;

   scram_snp #(
      .W       (AW),
      .ROUNDS  (ADDR_ROUNDS),
      .INVERSE (1'b0)
   ) u_addr_map (
      .data_i (addr_i),
      .key_i  (anonce_q),
      .data_o (phys_addr)
   );

   // byte diffusion, both directions
   logic [DATA_W-1:0] wdata_diff;
   logic [DATA_W-1:0] ram_wdata;
   logic [DATA_W-1:0] ram_rdata;
   logic [DATA_W-1:0] rd_mix;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      scram_snp #(
         .W       (8),
         .ROUNDS  (BYTE_ROUNDS),
         .INVERSE (1'b0)
      ) u_fwd (
         .data_i (wdata_i[8*b +: 8]),
         .key_i  (8'h00),
         .data_o (wdata_diff[8*b +: 8])
      );

      scram_snp #(
         .W       (8),
         .ROUNDS  (BYTE_ROUNDS),
         .INVERSE (1'b1)
      ) u_inv (
         .data_i (rd_mix[8*b +: 8]),
         .key_i  (8'h00),
         .data_o (rdata_o[8*b +: 8])
      );
   end

   assign ram_wdata = wdata_diff ^ ks_word;

   scram_spram #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
   ) u_mem (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (req_i),
      .we_i    (we_i),
      .addr_i  (phys_addr),
      .wdata_i (ram_wdata),
      .be_i    (be_i),
      .rdata_o (ram_rdata)
   );

   // read response stage
   logic              rvalid_q;
   logic [DATA_W-1:0] ks_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rvalid_q <= 1'b0;
         ks_q     <= '0;
      end else begin
         rvalid_q <= req_i && !we_i;
         if (req_i && !we_i) begin
            ks_q <= ks_word;
         end
      end
   end

   assign rd_mix   = ram_rdata ^ ks_q;
   assign rvalid_o = rvalid_q;

   assert_rvalid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && !we_i) |=> rvalid_o);

   assert_rvalid_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_i && !we_i) |=> !rvalid_o);

   assert_iv_nonce_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !key_load_i |=> (ks_iv_o[IV_W-1:AW] == $past(ks_iv_o[IV_W-1:AW])));

endmodule

// File: tb/scram_ram_bench.sv
`timescale 1ns/1ps
module scram_ram_bench;

   // clock and reset
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // main instance: 64 x 32, both networks on
   logic         key_load = 0;
   logic [127:0] key      = '0;
   logic [57:0]  dn       = '0;
   logic [5:0]   an       = '0;
   logic         req = 0, we = 0;
   logic [5:0]   addr  = '0;
   logic [31:0]  wdata = '0;
   logic [3:0]   be    = '0;
   logic         rvalid;
   logic [31:0]  rdata;
   logic [63:0]  iv;
   logic [127:0] kso;
   logic [63:0]  ks;

   // wide instance: 16 x 128, replicated keystream, networks off
   logic         w_key_load = 0;
   logic [127:0] w_key   = '0;
   logic [59:0]  w_dn    = '0;
   logic [3:0]   w_an    = '0;
   logic         w_req = 0, w_we = 0;
   logic [3:0]   w_addr  = '0;
   logic [127:0] w_wdata = '0;
   logic [15:0]  w_be    = '0;
   logic         w_rvalid;
   logic [127:0] w_rdata;
   logic [63:0]  w_iv;
   logic [127:0] w_kso;
   logic [63:0]  w_ks;

   // stand-in cipher core
   function automatic logic [63:0] ksf(input logic [63:0] v, input logic [127:0] k);
      return ((v ^ k[63:0]) * 64'h9E3779B97F4A7C15) ^ {k[127:96] ^ v[31:0], k[95:64]};
   endfunction

   assign ks   = ksf(iv, kso);
   assign w_ks = ksf(w_iv, w_kso);

   scram_ram #(
      .DEPTH (64), .DATA_W (32), .BYTE_ROUNDS (2), .ADDR_ROUNDS (2), .REPLICATE (1'b0)
   ) u_scram_ram (
      .clk_i (clk), .rst_ni (rst_n), .key_load_i (key_load), .key_i (key),
      .dnonce_i (dn), .anonce_i (an), .req_i (req), .we_i (we), .addr_i (addr),
      .wdata_i (wdata), .be_i (be), .rvalid_o (rvalid), .rdata_o (rdata),
      .ks_iv_o (iv), .ks_key_o (kso), .ks_i (ks)
   );

   scram_ram #(
      .DEPTH (16), .DATA_W (128), .BYTE_ROUNDS (0), .ADDR_ROUNDS (0), .REPLICATE (1'b1)
   ) u_scram_ram_wide (
      .clk_i (clk), .rst_ni (rst_n), .key_load_i (w_key_load), .key_i (w_key),
      .dnonce_i (w_dn), .anonce_i (w_an), .req_i (w_req), .we_i (w_we), .addr_i (w_addr),
      .wdata_i (w_wdata), .be_i (w_be), .rvalid_o (w_rvalid), .rdata_o (w_rdata),
      .ks_iv_o (w_iv), .ks_key_o (w_kso), .ks_i (w_ks)
   );

   // model of the requirements
   logic [127:0] m_key = '0;
   logic [57:0]  m_dn  = '0;
   logic [5:0]   m_an  = '0;
   logic [31:0]  m_mem [64];

   function automatic logic [3:0] sb(input logic [3:0] x, input bit inv);
      logic [3:0] t [16];
      t = '{4'hC,4'h5,4'h6,4'hB,4'h9,4'h0,4'hA,4'hD,4'h3,4'hE,4'hF,4'h8,4'h4,4'h7,4'h1,4'h2};
      if (!inv) return t[x];
      for (int i = 0; i < 16; i++) if (t[i] == x) return i[3:0];
      return 4'h0;
   endfunction

   function automatic logic [15:0] snp(input logic [15:0] d, input logic [15:0] k,
                                       input int w, input int rounds, input bit inv);
      logic [15:0] s, t;
      s = d;
      if (!inv) begin
         for (int r = 0; r < rounds; r++) begin
            s = s ^ k;
            for (int n = 0; n < w/4; n++) s[4*n +: 4] = sb(s[4*n +: 4], 1'b0);
            t = s;
            for (int i = 0; i < w; i++) t[i] = s[w-1-i];
            s = t;
            for (int i = 0; i < w/2; i++) begin
               s[i]       = t[2*i];
               s[i + w/2] = t[2*i + 1];
            end
         end
         s = s ^ k;
      end else begin
         s = s ^ k;
         for (int r = 0; r < rounds; r++) begin
            t = s;
            for (int i = 0; i < w/2; i++) begin
               t[2*i]     = s[i];
               t[2*i + 1] = s[i + w/2];
            end
            for (int i = 0; i < w; i++) s[i] = t[w-1-i];
            for (int n = 0; n < w/4; n++) s[4*n +: 4] = sb(s[4*n +: 4], 1'b1);
            s = s ^ k;
         end
      end
      return s;
   endfunction

   function automatic logic [5:0] m_phys(input logic [5:0] a);
      logic [15:0] r;
      r = snp({10'b0, a}, {10'b0, m_an}, 6, 2, 1'b0);
      return r[5:0];
   endfunction

   function automatic logic [31:0] m_ks(input logic [5:0] a);
      logic [63:0] r;
      r = ksf({m_dn, a}, m_key);
      return r[31:0];
   endfunction

   function automatic logic [31:0] m_read(input logic [5:0] a);
      logic [31:0] c, r;
      logic [15:0] t;
      c = m_mem[m_phys(a)] ^ m_ks(a);
      for (int b = 0; b < 4; b++) begin
         t = snp({8'b0, c[8*b +: 8]}, 16'h0, 8, 2, 1'b1);
         r[8*b +: 8] = t[7:0];
      end
      return r;
   endfunction

   task automatic m_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] e);
      logic [5:0]  p;
      logic [31:0] k;
      logic [15:0] t;
      p = m_phys(a);
      k = m_ks(a);
      for (int b = 0; b < 4; b++) begin
         if (e[b]) begin
            t = snp({8'b0, d[8*b +: 8]}, 16'h0, 8, 2, 1'b0);
            m_mem[p][8*b +: 8] = t[7:0] ^ k[8*b +: 8];
         end
      end
   endtask

   task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] pat(input logic [5:0] a, input logic [31:0] salt);
      return 32'h5A3C0000 ^ ({26'b0, a} * 32'h01010101) ^ salt;
   endfunction

   // driving tasks: entered just after a falling edge
   task automatic do_wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] e);
      req = 1; we = 1; addr = a; wdata = d; be = e;
      m_write(a, d, e);
      @(negedge clk);
      req = 0; we = 0; be = '0;
      check("R8 no valid after write", {127'b0, rvalid}, 128'd0);
   endtask

   task automatic do_rd(input logic [5:0] a, input string tag);
      logic [31:0] exp;
      req = 1; we = 0; addr = a;
      exp = m_read(a);
      #1;
      check("R3 counter value", {64'b0, iv}, {64'b0, m_dn, a});
      @(negedge clk);
      req = 0;
      check("R8 valid one cycle after read", {127'b0, rvalid}, 128'd1);
      check(tag, {96'b0, rdata}, {96'b0, exp});
   endtask

   task automatic do_load(input logic [127:0] k, input logic [57:0] d, input logic [5:0] n,
                          input bit with_wr, input bit with_rd,
                          input logic [5:0] a, input logic [31:0] v);
      logic [31:0] exp;
      key_load = 1; key = k; dn = d; an = n;
      exp = '0;
      if (with_wr) begin
         req = 1; we = 1; addr = a; wdata = v; be = 4'hF;
         m_write(a, v, 4'hF);
      end else if (with_rd) begin
         req = 1; we = 0; addr = a;
         exp = m_read(a);
      end
      @(negedge clk);
      key_load = 0; req = 0; we = 0; be = '0;
      m_key = k; m_dn = d; m_an = n;
      if (with_rd) begin
         check("R2 same-cycle read uses old key set", {96'b0, rdata}, {96'b0, exp});
      end
      check("R2 key taken at load", kso, k);
      check("R2 data nonce taken at load", {64'b0, iv[63:6]}, {70'b0, d});
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R8 watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      logic [127:0] wexp;
      logic [63:0]  k0, k1;
      logic [127:0] wpat;

      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      check("R1 key zero after reset", kso, 128'd0);
      check("R1 nonce zero after reset", {64'b0, iv}, 128'd0);
      check("R8 no valid after reset", {127'b0, rvalid}, 128'd0);
      check("R1 wide key zero after reset", w_kso, 128'd0);
      @(negedge clk);

      // R4 R7: full sweep under the zero key set
      for (int a = 0; a < 64; a++) do_wr(a[5:0], pat(a[5:0], 32'h0), 4'hF);
      for (int a = 0; a < 64; a++) do_rd(a[5:0], "R4 R7 round trip zero key");
      check("R4 model matches plaintext", {96'b0, m_read(6'd17)}, {96'b0, pat(6'd17, 32'h0)});
      @(negedge clk);
      check("R8 valid is a single pulse", {127'b0, rvalid}, 128'd0);

      // R9: new key set, no rewrite
      do_load(128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0, 58'h2B4D6F8A1C3E5A7, 6'h2D, 0, 0, 6'h0, 32'h0);
      for (int a = 0; a < 64; a++) do_rd(a[5:0], "R9 R7 stale contents after key change");

      // R4 R5 R7: rewrite and read under the new set
      for (int a = 0; a < 64; a++) do_wr(a[5:0], pat(a[5:0], 32'hDEADBEEF), 4'hF);
      for (int a = 0; a < 64; a++) do_rd(a[5:0], "R4 R5 round trip loaded key");

      // R6: partial writes
      do_wr(6'd3,  32'h11111111, 4'b0001);
      do_wr(6'd17, 32'h22222222, 4'b0110);
      do_wr(6'd40, 32'h33333333, 4'b1000);
      do_wr(6'd63, 32'h44444444, 4'b1010);
      do_wr(6'd0,  32'h55555555, 4'b0000);
      do_rd(6'd3,  "R6 byte enables 0001");
      do_rd(6'd17, "R6 byte enables 0110");
      do_rd(6'd40, "R6 byte enables 1000");
      do_rd(6'd63, "R6 byte enables 1010");
      do_rd(6'd0,  "R6 no enables leaves word");
      check("R6 untouched word keeps plaintext", {96'b0, m_read(6'd0)},
            {96'b0, pat(6'd0, 32'hDEADBEEF)});

      // R2: load together with a write, then together with a read
      do_load(128'h13579BDF2468ACE0FEDCBA9876543210, 58'h1A2B3C4D5E6F708, 6'h16, 1, 0,
              6'd5, 32'hCAFEF00D);
      do_rd(6'd5, "R2 R9 write scrambled under old key set");
      do_load(128'h00112233445566778899AABBCCDDEEFF, 58'h3FFFFFFFFFFFFFF, 6'h3F, 0, 1,
              6'd9, 32'h0);
      do_rd(6'd9, "R9 read under newest key set");
      do_wr(6'd9, 32'h600DCAFE, 4'hF);
      do_rd(6'd9, "R4 round trip newest key set");

      // R10: wide instance, replicated keystream, networks bypassed
      for (int a = 0; a < 16; a++) begin
         wpat = {32'h01234567 * (a + 1), 32'h89ABCDEF ^ a, 32'hC0DE0000 + a, 32'h5555AAAA ^ (a << 8)};
         w_req = 1; w_we = 1; w_addr = a[3:0]; w_wdata = wpat; w_be = '1;
         @(negedge clk);
         w_req = 0; w_we = 0; w_be = '0;
      end
      for (int a = 0; a < 16; a++) begin
         wpat = {32'h01234567 * (a + 1), 32'h89ABCDEF ^ a, 32'hC0DE0000 + a, 32'h5555AAAA ^ (a << 8)};
         w_req = 1; w_we = 0; w_addr = a[3:0];
         @(negedge clk);
         w_req = 0;
         check("R10 wide round trip", w_rdata, wpat);
         check("R8 wide valid", {127'b0, w_rvalid}, 128'd1);
      end
      w_key_load = 1; w_key = 128'hA5A5A5A5_5A5A5A5A_F00DFACE_0BADBEEF; w_dn = 60'h123456789ABCDEF;
      @(negedge clk);
      w_key_load = 0;
      for (int a = 0; a < 16; a++) begin
         wpat = {32'h01234567 * (a + 1), 32'h89ABCDEF ^ a, 32'hC0DE0000 + a, 32'h5555AAAA ^ (a << 8)};
         k0 = ksf({60'b0, a[3:0]}, 128'd0);
         k1 = ksf({w_dn, a[3:0]}, w_key);
         wexp = wpat ^ {2{k0 ^ k1}};
         w_req = 1; w_we = 0; w_addr = a[3:0];
         @(negedge clk);
         w_req = 0;
         check("R10 replicated keystream after key change", w_rdata, wexp);
      end

      done = 1'b1;
      finish_run();
   end

endmodule